// File: doc/BRIEF.md
# Teletext Bit Request Sequencer

This block paces the serial handover of teletext data from an external source into a video encoder. On video lines chosen for insertion it sends the source a train of request pulses, one per wanted bit. A fixed number of crystal-rate ticks after each pulse it samples one bit from the serial input. Each captured bit leaves the block with a one-cycle valid strobe, and a per-line counter shows how many bits have been taken so far. The insertion window has a bit budget that follows the selected teletext standard. The window opens at a programmable tick offset after the start of the line. The bit pitch is a fractional number of ticks, given as a numerator over a denominator.

All sequencing runs on the crystal-rate tick, which is a clock enable on the fast system clock. Line start is honoured only on a tick. At line start the block latches the line's selection from one of two 32-entry masks, one mask per field, and the window budget. The request output pin can be switched to carry a square wave at half the tick rate in place of the requests.

Top module: `ttx_req_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the request pin, `bit_vld` and `bit_cnt` are all zero.
- R2: A line is selected when `line_num - BASE_LINE` lies in 0..31 and the mask bit at that index is 1. The mask is `mask_f0` when `field_id` is 0 and `mask_f1` when it is 1. The selection is latched on the line-start tick.
- R3: Let hpos be 0 on the first tick after the line-start tick, rising by one on each later tick. Request k (counted from 0) is issued on the tick where hpos equals `h_offset + ceil(k*rate_num/rate_den)`, with `rate_num >= rate_den >= 1`.
- R4: Each line carries at most 360 requests when `std_sel` is 0, 296 when it is 1, and 288 when it is 2 or 3.
- R5: Each request shows on the pin as a one-clock high in the cycle after its tick edge. Lines that are not selected carry no requests.
- R6: The serial input is sampled on the tick that comes `samp_dly` ticks after the request tick, where 0 counts as 1. The bit appears on `bit_dat` with `bit_vld` high for exactly the following clock cycle.
- R7: `bit_cnt` equals the number of bits captured since the latest line-start tick, and that tick clears it.
- R8: State advances only in cycles with `xtal_en` high. A `line_start` pulse in a cycle without `xtal_en` has no effect.
- R9: With `clk_out_mode` high, the pin carries a register that flips on every tick and is cleared by reset. While the mode is high, no requests are issued and no bits are captured.
- R10: A line-start tick discards captures still pending from the previous line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_en | input | 1 | Crystal-rate tick enable |
| line_start | input | 1 | Start-of-line pulse, used on a tick |
| line_num | input | LINE_W | Current line number |
| field_id | input | 1 | Field flag, 0 first field, 1 second |
| mask_f0 | input | MASK_W | Line-enable mask for field 0 |
| mask_f1 | input | MASK_W | Line-enable mask for field 1 |
| std_sel | input | 2 | Teletext standard, sets window budget |
| h_offset | input | HPOS_W | Window start in ticks after line start |
| rate_num | input | RATE_W | Bit pitch numerator (ticks) |
| rate_den | input | RATE_W | Bit pitch denominator |
| samp_dly | input | DLY_W | Ticks from request to sample |
| clk_out_mode | input | 1 | Pin carries divided tick clock |
| ttx_din | input | 1 | Serial teletext input |
| ttx_req_o | output | 1 | Request strobe or divided clock |
| bit_dat | output | 1 | Captured bit |
| bit_vld | output | 1 | One-cycle valid for `bit_dat` |
| bit_cnt | output | 9 | Bits captured on current line |

## Verification
The bench uses the default parameters: a base line of 7, 32-bit masks, an 11-bit tick position and delays of up to 15 ticks. These are small enough to sweep every line from two below the mask range to two above it, in both fields. Full lines are run for all four standard codes, each with a different fractional pitch (3/2, 5/3, 1/1, 7/4), offset and delay, including the shortest delay, the zero delay and the longest. One of these runs uses a gapped tick with a stray untimed line-start pulse. The request ticks, capture ticks and sampled data are worked out arithmetically from the ceiling formula. That reaches the window end, the discarding of pending captures at a new line, and clock-output mode.

// File: rtl/ttx_req_pkg.sv
package ttx_req_pkg;

    localparam int unsigned TTX_CNT_W = 9;

    localparam int unsigned TTX_WIN_625_WST  = 360;
    localparam int unsigned TTX_WIN_525_WST  = 296;
    localparam int unsigned TTX_WIN_525_DATA = 288;

    typedef enum logic [1:0] {
        TTX_STD_625_WST  = 2'd0,
        TTX_STD_525_WST  = 2'd1,
        TTX_STD_525_DATA = 2'd2,
        TTX_STD_SPARE    = 2'd3
    } ttx_std_e;

    // per-line configuration captured on the line-start tick
    typedef struct packed {
        logic                 sel;
        logic [TTX_CNT_W-1:0] win;
    } ttx_line_cfg_t;

    // one captured bit
    typedef struct packed {
        logic vld;
        logic dat;
    } ttx_cap_t;

    function automatic logic [TTX_CNT_W-1:0] ttx_win_bits(input ttx_std_e s);
        case (s)
            TTX_STD_625_WST: return TTX_CNT_W'(TTX_WIN_625_WST);
            TTX_STD_525_WST: return TTX_CNT_W'(TTX_WIN_525_WST);
            default:         return TTX_CNT_W'(TTX_WIN_525_DATA);
        endcase
    endfunction

endpackage

// File: rtl/ttx_line_gate.sv
module ttx_line_gate
    import ttx_req_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int MASK_W    = 32,
    parameter int BASE_LINE = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ls_tick,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_id,
    input  logic [MASK_W-1:0] mask_f0,
    input  logic [MASK_W-1:0] mask_f1,
    input  logic [1:0]        std_sel,
    output ttx_line_cfg_t     cfg_q
);
    localparam int IDX_W = $clog2(MASK_W);
    localparam logic [LINE_W-1:0] LO_LINE = LINE_W'(BASE_LINE);
    localparam logic [LINE_W-1:0] HI_LINE = LINE_W'(BASE_LINE + MASK_W);

    logic [LINE_W-1:0] rel_line;
    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic [MASK_W-1:0] mask_sel;
    ttx_line_cfg_t     cfg_d;

    assign rel_line = line_num - LO_LINE;
    assign idx      = rel_line[IDX_W-1:0];
    assign in_range = (line_num >= LO_LINE) && (line_num < HI_LINE);
    assign mask_sel = field_id ? mask_f1 : mask_f0;

    always_comb begin
        cfg_d.sel = in_range && mask_sel[idx];
        cfg_d.win = ttx_win_bits(ttx_std_e'(std_sel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (ls_tick) begin
            cfg_q <= cfg_d;
        end
    end

    // window budget never exceeds the longest standard
    AST_WIN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cfg_q.win <= TTX_CNT_W'(TTX_WIN_625_WST)); // R4

endmodule

// File: rtl/ttx_bit_pacer.sv
module ttx_bit_pacer
    import ttx_req_pkg::*;
#(
    parameter int HPOS_W = 11,
    parameter int RATE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 ls_tick,
    input  logic                 clk_mode,
    input  ttx_line_cfg_t        cfg,
    input  logic [HPOS_W-1:0]    h_offset,
    input  logic [RATE_W-1:0]    rate_num,
    input  logic [RATE_W-1:0]    rate_den,
    output logic                 fire,
    output logic                 req_q,
    output logic [TTX_CNT_W-1:0] nreq
);
    localparam int ACC_W = RATE_W + 1;

    logic [HPOS_W-1:0] hpos;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  acc_sum;
    logic [ACC_W-1:0]  num_x;
    logic [ACC_W-1:0]  den_x;
    logic              in_win;

    assign num_x   = {1'b0, rate_num};
    assign den_x   = {1'b0, rate_den};
    assign acc_sum = acc + den_x;
    assign in_win  = cfg.sel && !clk_mode && (hpos >= h_offset) && (nreq < cfg.win);
    assign fire    = en && !ls_tick && in_win && (acc_sum >= num_x);

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos  <= '0;
            acc   <= '0;
            nreq  <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= fire;
            if (ls_tick) begin
                hpos <= '0;
                acc  <= num_x - den_x;
                nreq <= '0;
            end else if (en) begin
                if (hpos != '1) begin
                    hpos <= hpos + HPOS_W'(1);
                end
                if (fire) begin
                    acc  <= acc_sum - num_x;
                    nreq <= nreq + TTX_CNT_W'(1);
                end else if (in_win) begin
                    acc <= acc_sum;
                end
            end
        end
    end

    AST_REQ_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (rst)
        nreq <= cfg.win); // R4

    AST_NREQ_STEP: assert property (@(posedge clk) disable iff (rst)
        req_q |-> (nreq != '0)); // R3

endmodule

// File: rtl/ttx_capture.sv
module ttx_capture
    import ttx_req_pkg::*;
#(
    parameter int DLY_MAX = 15,
    localparam int DLY_W  = $clog2(DLY_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 ls_tick,
    input  logic                 fire,
    input  logic [DLY_W-1:0]     samp_dly,
    input  logic                 din,
    output ttx_cap_t             cap,
    output logic [TTX_CNT_W-1:0] cnt
);
    logic             pend [DLY_MAX];
    logic [DLY_W-1:0] tap;
    logic             hit;

    always_comb begin
        if (samp_dly == '0) begin
            tap = DLY_W'(1);
        end else if (int'(samp_dly) > DLY_MAX) begin
            tap = DLY_W'(DLY_MAX);
        end else begin
            tap = samp_dly;
        end
    end

    assign hit = en && !ls_tick && pend[tap - DLY_W'(1)];

    // pending-request delay line, one stage per tick
    for (genvar i = 0; i < DLY_MAX; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || ls_tick) begin
                pend[i] <= 1'b0;
            end else if (en) begin
                if (i == 0) begin
                    pend[i] <= fire;
                end else begin
                    pend[i] <= pend[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
            cnt <= '0;
        end else begin
            cap.vld <= hit;
            if (hit) begin
                cap.dat <= din;
            end
            if (ls_tick) begin
                cnt <= '0;
            end else if (hit) begin
                cnt <= cnt + TTX_CNT_W'(1);
            end
        end
    end

    AST_VLD_HAS_COUNT: assert property (@(posedge clk) disable iff (rst)
        cap.vld |-> (cnt != '0)); // R7

    AST_VLD_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !cap.vld); // R8

endmodule

// File: rtl/ttx_req_seq.sv
module ttx_req_seq
    import ttx_req_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int MASK_W    = 32,
    parameter int BASE_LINE = 7,
    parameter int HPOS_W    = 11,
    parameter int RATE_W    = 8,
    parameter int DLY_MAX   = 15,
    localparam int DLY_W    = $clog2(DLY_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 xtal_en,
    input  logic                 line_start,
    input  logic [LINE_W-1:0]    line_num,
    input  logic                 field_id,
    input  logic [MASK_W-1:0]    mask_f0,
    input  logic [MASK_W-1:0]    mask_f1,
    input  logic [1:0]           std_sel,
    input  logic [HPOS_W-1:0]    h_offset,
    input  logic [RATE_W-1:0]    rate_num,
    input  logic [RATE_W-1:0]    rate_den,
    input  logic [DLY_W-1:0]     samp_dly,
    input  logic                 clk_out_mode,
    input  logic                 ttx_din,
    output logic                 ttx_req_o,
    output logic                 bit_dat,
    output logic                 bit_vld,
    output logic [TTX_CNT_W-1:0] bit_cnt
);
    logic                 ls_tick;
    ttx_line_cfg_t        line_cfg;
    logic                 fire;
    logic                 req_pulse;
    logic [TTX_CNT_W-1:0] nreq;
    ttx_cap_t             cap;
    logic                 tick_tog;

    assign ls_tick = xtal_en && line_start;

    ttx_line_gate #(
        .LINE_W   (LINE_W),
        .MASK_W   (MASK_W),
        .BASE_LINE(BASE_LINE)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .ls_tick (ls_tick),
        .line_num(line_num),
        .field_id(field_id),
        .mask_f0 (mask_f0),
        .mask_f1 (mask_f1),
        .std_sel (std_sel),
        .cfg_q   (line_cfg)
    );

    ttx_bit_pacer #(
        .HPOS_W(HPOS_W),
        .RATE_W(RATE_W)
    ) u_pacer (
        .clk     (clk),
        .rst     (rst),
        .en      (xtal_en),
        .ls_tick (ls_tick),
        .clk_mode(clk_out_mode),
        .cfg     (line_cfg),
        .h_offset(h_offset),
        .rate_num(rate_num),
        .rate_den(rate_den),
        .fire    (fire),
        .req_q   (req_pulse),
        .nreq    (nreq)
    );

    ttx_capture #(
        .DLY_MAX(DLY_MAX)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .en      (xtal_en),
        .ls_tick (ls_tick),
        .fire    (fire),
        .samp_dly(samp_dly),
        .din     (ttx_din),
        .cap     (cap),
        .cnt     (bit_cnt)
    );

    // divided tick clock for the alternate pin function
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_tog <= 1'b0;
        end else if (xtal_en) begin
            tick_tog <= ~tick_tog;
        end
    end

    assign ttx_req_o = clk_out_mode ? tick_tog : req_pulse;
    assign bit_dat   = cap.dat;
    assign bit_vld   = cap.vld;

    AST_REQ_ON_SELECTED: assert property (@(posedge clk) disable iff (rst)
        req_pulse |-> line_cfg.sel); // R5

    AST_REQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        req_pulse |-> $past(xtal_en)); // R8

    AST_CAPTURES_LE_REQUESTS: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= nreq); // R6

    AST_CLKMODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (clk_out_mode && $past(clk_out_mode)) |-> !req_pulse); // R9

endmodule

// File: tb/tb_ttx_req_seq.sv
module tb_ttx_req_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xtal_en = 1'b0;
    logic        line_start = 1'b0;
    logic [9:0]  line_num = '0;
    logic        field_id = 1'b0;
    logic [31:0] mask_f0 = 32'hA5C3_0F96;
    logic [31:0] mask_f1 = 32'h3C69_D2E1;
    logic [1:0]  std_sel = '0;
    logic [10:0] h_offset = '0;
    logic [7:0]  rate_num = 8'd1;
    logic [7:0]  rate_den = 8'd1;
    logic [3:0]  samp_dly = 4'd1;
    logic        clk_out_mode = 1'b0;
    logic        ttx_din = 1'b0;
    wire         ttx_req_o;
    wire         bit_dat;
    wire         bit_vld;
    wire [8:0]   bit_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    int hp_next = 0;
    bit sel_cur = 1'b0;
    int win_cur = 0;
    int exp_cnt = 0;
    bit tog_exp = 1'b0;
    bit done = 1'b0;

    ttx_req_seq dut (
        .clk(clk), .rst(rst), .xtal_en(xtal_en), .line_start(line_start),
        .line_num(line_num), .field_id(field_id), .mask_f0(mask_f0),
        .mask_f1(mask_f1), .std_sel(std_sel), .h_offset(h_offset),
        .rate_num(rate_num), .rate_den(rate_den), .samp_dly(samp_dly),
        .clk_out_mode(clk_out_mode), .ttx_din(ttx_din), .ttx_req_o(ttx_req_o),
        .bit_dat(bit_dat), .bit_vld(bit_vld), .bit_cnt(bit_cnt)
    );

    always #4 clk = ~clk;

    function automatic int f_bit(input int h);
        return (h ^ (h >> 1) ^ (h >> 3)) & 1;
    endfunction

    function automatic int win_of(input logic [1:0] s);
        if (s == 2'd0) return 360;
        if (s == 2'd1) return 296;
        return 288;
    endfunction

    function automatic bit sel_of();
        int idx;
        idx = int'(line_num) - 7;
        if (idx < 0 || idx >= 32) return 1'b0;
        return field_id ? mask_f1[idx] : mask_f0[idx];
    endfunction

    // request k lands at offset + ceil(k*num/den)
    function automatic bit is_req(input int h);
        int t;
        int k;
        t = h - int'(h_offset);
        if (t < 0 || !sel_cur || clk_out_mode) return 1'b0;
        k = (t * int'(rate_den)) / int'(rate_num);
        if (k >= win_cur) return 1'b0;
        return (k * int'(rate_num)) > ((t - 1) * int'(rate_den));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit en, input bit ls);
        bit er;
        bit ev;
        int ed;
        int deff;
        @(negedge clk);
        xtal_en    = en;
        line_start = ls;
        ttx_din    = f_bit(hp_next)[0];
        er = 1'b0;
        ev = 1'b0;
        ed = 0;
        deff = (samp_dly == 4'd0) ? 1 : int'(samp_dly);
        if (en) begin
            tog_exp = ~tog_exp;
            if (ls) begin
                sel_cur = sel_of();
                win_cur = win_of(std_sel);
                hp_next = 0;
                exp_cnt = 0;
            end else begin
                er = is_req(hp_next);
                ev = (hp_next - deff >= 0) && is_req(hp_next - deff);
                ed = f_bit(hp_next);
                if (ev) exp_cnt++;
                hp_next++;
            end
        end
        @(posedge clk);
        #2;
        if (clk_out_mode) check("R9 divided clock on pin", int'(ttx_req_o), int'(tog_exp));
        else              check("R2 R3 R4 R5 request pin", int'(ttx_req_o), int'(er));
        check("R6 R10 bit_vld", int'(bit_vld), int'(ev));
        if (ev) check("R6 bit_dat", int'(bit_dat), ed);
        check("R7 bit_cnt", int'(bit_cnt), exp_cnt);
    endtask

    task automatic run_line(input logic [1:0] s, input int num, input int den,
                            input int off, input int dly, input int nsteps,
                            input int gap, input int ln, input bit fld);
        std_sel  = s;
        rate_num = 8'(num);
        rate_den = 8'(den);
        h_offset = 11'(off);
        samp_dly = 4'(dly);
        line_num = 10'(ln);
        field_id = fld;
        step(1'b1, 1'b1);
        for (int i = 0; i < nsteps; i++) begin
            bit en;
            en = (gap == 0) || ((i % gap) != (gap - 1));
            // R8: stray line_start without a tick must be ignored
            step(en, !en && (i > 90) && (i < 100));
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 pin in reset", int'(ttx_req_o), 0);
        check("R1 bit_vld in reset", int'(bit_vld), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1 pin after reset", int'(ttx_req_o), 0);
        check("R1 bit_vld after reset", int'(bit_vld), 0);
        check("R1 bit_cnt after reset", int'(bit_cnt), 0);
        tog_exp = 1'b0;

        // R2: sweep every line around the mask range in both fields
        for (int f = 0; f < 2; f++) begin
            for (int ln = 5; ln <= 40; ln++) begin
                run_line(2'd2, 1, 1, 1, 2, 6, 0, ln, f[0]);
            end
        end

        // R3 R4: full windows for every standard code
        run_line(2'd0, 3, 2, 5, 3, 600, 0, 8, 1'b0);
        run_line(2'd1, 5, 3, 9, 7, 820, 3, 7, 1'b1);
        run_line(2'd2, 1, 1, 0, 0, 300, 0, 8, 1'b0);
        run_line(2'd3, 7, 4, 3, 15, 540, 0, 7, 1'b1);

        // R10: cut a line short with captures still pending
        run_line(2'd0, 1, 1, 0, 15, 100, 0, 8, 1'b0);
        run_line(2'd0, 1, 1, 0, 15, 50, 0, 8, 1'b0);
        // R5: unselected line, out of mask range
        run_line(2'd0, 1, 1, 0, 2, 50, 0, 5, 1'b0);

        // R9: clock output mode on a selected line
        clk_out_mode = 1'b1;
        run_line(2'd0, 1, 1, 0, 1, 60, 2, 8, 1'b0);
        clk_out_mode = 1'b0;
        run_line(2'd2, 2, 1, 2, 4, 40, 0, 8, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule